// File: doc/BRIEF.md
# Shared-Line Interrupt Pin Delivery Engine

This block sits beside an interrupt redirection table. It turns per-pin line events into interrupt messages. Several sources may drive the same pin, so each pin keeps a signed, saturating count of its asserts and deasserts. A message is requested only when the count rises from zero to one. Requests wait in a per-pin bitmap and are sent one at a time over a valid/ready handshake, lowest pin first. Each message carries the routing fields of that pin's table entry.

The table is owned by a neighbouring register file. All of its entries are presented in parallel on one flat bus. The block never stores those entries. It returns strobes that set or clear the remote-IRR bit of an entry. When a level-triggered pin is delivered, the block raises the set strobe for that pin. When an end-of-interrupt vector is broadcast, the block raises the clear strobe for every matching pin and queues the pin again if its line is still held.

The register file also issues a delivery-check request after it rewrites an entry. This lets a pin that was held while masked or blocked be delivered.

Top module: `pin_delivery_engine`

## Requirements
- R1: After reset every count is zero, no request is pending, and `msgValid`, `cmdErr`, `underflowErr`, `rirrSet` and `rirrClr` are all low.
- R2: Command codes on `cmdOp` are: 0 adds one to the count, 1 subtracts one, 2 adds one and then subtracts one in the same cycle. A request is queued only when the count goes from 0 to 1, which for code 2 is its first step. Every other count change queues nothing.
- R3: `underflowErr` is high for one cycle, one cycle after a command leaves the pin's count below zero. The count change is still applied.
- R4: A command whose 6-bit `cmdPin` is at or above the pin count raises `cmdErr` one cycle later and changes no count and no request.
- R5: A pin whose entry has bit 16 set (masked) is never offered. A queued request for a pin that becomes masked is discarded.
- R6: The offered message takes its fields from the selected entry: vector from bits 7:0, delivery mode from bits 10:8, destination from bits 63:56, trigger level from bit 15, and `msgPhys` high when bit 11 is zero.
- R7: In the cycle a message for a level-triggered pin (bit 15 set) is accepted, `rirrSet` has exactly that pin's bit high. An edge-triggered pin raises no `rirrSet`.
- R8: In a cycle with `eoiValid`, `rirrClr` is high for every pin whose entry has bit 14 set and whose vector equals `eoiVector`. Each such pin whose count is positive and which is unmasked is queued again.
- R9: A delivery-check request for a pin queues it only when the pin is unmasked, its entry bit 14 is clear and its count is positive.
- R10: When several requests wait, the lowest-numbered pin is offered. Exactly one request is retired for each cycle in which `msgValid` and `msgReady` are both high.
- R11: A count saturates at +2^(CNT_W-1)-1 and at -2^(CNT_W-1) instead of wrapping.
- R12: Command code 3 changes no count and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Line command strobe |
| cmdOp | input | 2 | Command code (R2, R12) |
| cmdPin | input | 6 | Target pin; may be out of range |
| chkValid | input | 1 | Delivery-check request strobe |
| chkPin | input | 5 | Pin to check |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector being acknowledged |
| entryFlat | input | 2048 | All table entries, 64 bits each, pin 0 in the low bits |
| msgReady | input | 1 | Consumer accepts the offered message |
| msgValid | output | 1 | A message is offered |
| msgVector | output | 8 | Message vector |
| msgDelMode | output | 3 | Message delivery mode |
| msgDest | output | 8 | Message destination |
| msgPhys | output | 1 | High for physical destination mode |
| msgLevel | output | 1 | High for level-triggered pin |
| rirrSet | output | 32 | Per-pin strobe to set the remote-IRR bit |
| rirrClr | output | 32 | Per-pin strobe to clear the remote-IRR bit |
| cmdErr | output | 1 | Out-of-range command flag |
| underflowErr | output | 1 | Negative count flag |

## Verification
The bench drives a pin from negative back through zero. It also checks that a second assert on an already-held pin stays silent. A design that fired on any increase, or on a -1 to 0 step, would emit extra messages here. It applies 130 asserts and 130 deasserts to single pins. A wrapping counter would then report underflow, or lose the 0-to-1 edge that must follow. Two level pins share one vector. An end-of-interrupt must clear both and re-deliver only the pin still held, while a foreign vector must touch neither. Further cases cover a request stalled by a low `msgReady` that must then drain lowest pin first, a queued request whose pin is masked before it is served, a check request blocked by a set remote-IRR bit, and out-of-range and reserved commands that must leave every count unchanged.

// File: rtl/pde_pkg.sv
`timescale 1ns/1ps
package pde_pkg;
  // Layout of one redirection entry as decoded by this block
  localparam int ENTRY_W   = 64;
  localparam int VEC_LSB   = 0;
  localparam int VEC_W     = 8;
  localparam int DELM_LSB  = 8;
  localparam int DELM_W    = 3;
  localparam int DMODE_BIT = 11;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;
  localparam int DEST_W    = 8;

  typedef enum logic [1:0] {
    OP_RAISE = 2'd0,
    OP_DROP  = 2'd1,
    OP_BLIP  = 2'd2,
    OP_RSVD  = 2'd3
  } pinOp_e;

  typedef struct packed {
    logic doInc;
    logic doDec;
    logic doPulse;
    logic doCheck;
    logic doEoi;
    logic doGrant;
  } ctrlStrobe_t;
endpackage

// File: rtl/pde_ctrl.sv
`timescale 1ns/1ps
module pde_ctrl import pde_pkg::*; #(
  parameter int NUM_PINS  = 32,
  parameter int CMD_PIN_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [CMD_PIN_W-1:0] cmdPin,
  input  logic                 chkValid,
  input  logic                 eoiValid,
  input  logic                 msgValid,
  input  logic                 msgReady,
  output ctrlStrobe_t          stb,
  output logic                 cmdErr
);
  logic inRange;
  assign inRange = 32'(cmdPin) < 32'(NUM_PINS);

  always_comb begin
    stb = '0;
    if (cmdValid && inRange) begin
      case (pinOp_e'(cmdOp))
        OP_RAISE: stb.doInc   = 1'b1;
        OP_DROP:  stb.doDec   = 1'b1;
        OP_BLIP:  stb.doPulse = 1'b1;
        default:  ;
      endcase
    end
    stb.doCheck = chkValid;
    stb.doEoi   = eoiValid;
    stb.doGrant = msgValid && msgReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdErr <= 1'b0;
    else       cmdErr <= cmdValid && !inRange;
  end

  // R4
  bad_pin_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && 32'(cmdPin) >= 32'(NUM_PINS)) |=> cmdErr);

  // R12
  rsvd_op_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 2'd3) |-> !(stb.doInc || stb.doDec || stb.doPulse));
endmodule

// File: rtl/pde_datapath.sv
`timescale 1ns/1ps
module pde_datapath import pde_pkg::*; #(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8,
  parameter int PIN_W    = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 stb,
  input  logic [PIN_W-1:0]            cmdIdx,
  input  logic [PIN_W-1:0]            chkIdx,
  input  logic [VEC_W-1:0]            eoiVector,
  input  logic [NUM_PINS*ENTRY_W-1:0] entryFlat,
  output logic                        msgValid,
  output logic [VEC_W-1:0]            msgVector,
  output logic [DELM_W-1:0]           msgDelMode,
  output logic [DEST_W-1:0]           msgDest,
  output logic                        msgPhys,
  output logic                        msgLevel,
  output logic [NUM_PINS-1:0]         rirrSet,
  output logic [NUM_PINS-1:0]         rirrClr,
  output logic                        underflowErr
);
  localparam logic [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [NUM_PINS-1:0] pendQ, avail, setReq, grantOne, selOne, negHit;
  logic [NUM_PINS-1:0] maskV, rirrV, levelV;
  logic [PIN_W-1:0]    sel;
  logic [ENTRY_W-1:0]  entrySel;
  logic                unusedSelBits;
  logic                anyCmd;

  assign anyCmd = stb.doInc || stb.doDec || stb.doPulse;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [PIN_W-1:0] MY_IDX = PIN_W'(p);
    logic [CNT_W-1:0] cntQ, cntUp, cntDn, cntNext;
    logic hitCmd, cntPos, fireCmd, eoiMatch;

    assign maskV[p]  = entryFlat[p*ENTRY_W + MASK_BIT];
    assign rirrV[p]  = entryFlat[p*ENTRY_W + RIRR_BIT];
    assign levelV[p] = entryFlat[p*ENTRY_W + TRIG_BIT];

    assign hitCmd = anyCmd && (cmdIdx == MY_IDX);
    assign cntPos = !cntQ[CNT_W-1] && (cntQ != '0);
    assign cntUp  = (cntQ == CNT_MAX) ? cntQ : cntQ + CNT_ONE;
    assign cntDn  = (cntQ == CNT_MIN) ? cntQ : cntQ - CNT_ONE;

    always_comb begin
      cntNext = cntQ;
      if (hitCmd) begin
        if (stb.doInc)      cntNext = cntUp;
        else if (stb.doDec) cntNext = cntDn;
        else                cntNext = cntUp - CNT_ONE;
      end
    end

    assign fireCmd  = hitCmd && (stb.doInc || stb.doPulse) && (cntQ == '0);
    assign eoiMatch = stb.doEoi && rirrV[p] &&
                      (entryFlat[p*ENTRY_W + VEC_LSB +: VEC_W] == eoiVector);
    assign rirrClr[p] = eoiMatch;
    assign negHit[p]  = hitCmd && cntNext[CNT_W-1];
    assign setReq[p]  = fireCmd || (eoiMatch && cntPos) ||
                        (stb.doCheck && (chkIdx == MY_IDX) && !rirrV[p] && cntPos);

    always_ff @(posedge clk) begin
      if (!rstN) cntQ <= '0;
      else       cntQ <= cntNext;
    end

    // R11
    sat_top_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ == CNT_MAX) |=> (cntQ != CNT_MIN));
    // R11
    sat_bottom_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ == CNT_MIN) |=> (cntQ != CNT_MAX));
    // R10
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[p] && !grantOne[p]) |=> (pendQ[p] || maskV[p]));
    // R8
    clr_needs_rirr_chk: assert property (@(posedge clk) disable iff (!rstN)
      rirrClr[p] |-> (stb.doEoi && rirrV[p]));
  end

  assign avail    = pendQ & ~maskV;
  assign msgValid = |avail;
  assign selOne   = avail & (~avail + NUM_PINS'(1));
  assign grantOne = stb.doGrant ? selOne : '0;
  assign rirrSet  = grantOne & levelV;

  always_comb begin
    sel = '0;
    for (int i = NUM_PINS-1; i >= 0; i--) begin
      if (avail[i]) sel = PIN_W'(i);
    end
  end

  assign entrySel      = entryFlat[32'(sel)*ENTRY_W +: ENTRY_W];
  assign unusedSelBits = ^entrySel;
  assign msgVector     = entrySel[VEC_LSB +: VEC_W];
  assign msgDelMode    = entrySel[DELM_LSB +: DELM_W];
  assign msgDest       = entrySel[DEST_LSB +: DEST_W];
  assign msgPhys       = !entrySel[DMODE_BIT];
  assign msgLevel      = entrySel[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ        <= '0;
      underflowErr <= 1'b0;
    end else begin
      pendQ        <= ((pendQ & ~grantOne) | setReq) & ~maskV;
      underflowErr <= |negHit;
    end
  end

  // R7
  set_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rirrSet != '0) |-> (msgValid && stb.doGrant && msgLevel));
  // R5
  no_masked_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !entrySel[MASK_BIT]);
endmodule

// File: rtl/pin_delivery_engine.sv
`timescale 1ns/1ps
module pin_delivery_engine import pde_pkg::*; #(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 cmdValid,
  input  logic [1:0]                           cmdOp,
  input  logic [$clog2(NUM_PINS):0]            cmdPin,
  input  logic                                 chkValid,
  input  logic [$clog2(NUM_PINS)-1:0]          chkPin,
  input  logic                                 eoiValid,
  input  logic [VEC_W-1:0]                     eoiVector,
  input  logic [NUM_PINS*ENTRY_W-1:0]          entryFlat,
  input  logic                                 msgReady,
  output logic                                 msgValid,
  output logic [VEC_W-1:0]                     msgVector,
  output logic [DELM_W-1:0]                    msgDelMode,
  output logic [DEST_W-1:0]                    msgDest,
  output logic                                 msgPhys,
  output logic                                 msgLevel,
  output logic [NUM_PINS-1:0]                  rirrSet,
  output logic [NUM_PINS-1:0]                  rirrClr,
  output logic                                 cmdErr,
  output logic                                 underflowErr
);
  localparam int PIN_W     = $clog2(NUM_PINS);
  localparam int CMD_PIN_W = PIN_W + 1;

  ctrlStrobe_t stb;

  pde_ctrl #(.NUM_PINS(NUM_PINS), .CMD_PIN_W(CMD_PIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPin(cmdPin), .chkValid(chkValid), .eoiValid(eoiValid),
    .msgValid(msgValid), .msgReady(msgReady), .stb(stb), .cmdErr(cmdErr)
  );

  pde_datapath #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .PIN_W(PIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdIdx(cmdPin[PIN_W-1:0]),
    .chkIdx(chkPin), .eoiVector(eoiVector), .entryFlat(entryFlat),
    .msgValid(msgValid), .msgVector(msgVector), .msgDelMode(msgDelMode),
    .msgDest(msgDest), .msgPhys(msgPhys), .msgLevel(msgLevel),
    .rirrSet(rirrSet), .rirrClr(rirrClr), .underflowErr(underflowErr)
  );
endmodule

// File: tb/pin_delivery_engine_test.sv
`timescale 1ns/1ps
module pin_delivery_engine_test;
  localparam int NP   = 32;
  localparam int CW   = 8;
  localparam int MAXC = 2**(CW-1) - 1;
  localparam int MINC = -(2**(CW-1));

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, cmdValid, chkValid, eoiValid, msgReady;
  logic [1:0] cmdOp;
  logic [5:0] cmdPin;
  logic [4:0] chkPin;
  logic [7:0] eoiVector;
  logic [NP*64-1:0] entryFlat;
  logic msgValid, msgPhys, msgLevel, cmdErr, underflowErr;
  logic [7:0] msgVector, msgDest;
  logic [2:0] msgDelMode;
  logic [NP-1:0] rirrSet, rirrClr;

  // bench-owned redirection table
  logic [7:0] tVec [NP];
  logic [2:0] tDelm[NP];
  logic [7:0] tDest[NP];
  logic tDm[NP], tLevel[NP], tMask[NP], tRirr[NP];

  always_comb begin
    entryFlat = '0;
    for (int p = 0; p < NP; p++)
      entryFlat[p*64 +: 64] = {tDest[p], 39'b0, tMask[p], tLevel[p], tRirr[p],
                               2'b0, tDm[p], tDelm[p], tVec[p]};
  end

  pin_delivery_engine #(.NUM_PINS(NP), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPin(cmdPin),
    .chkValid(chkValid), .chkPin(chkPin), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .entryFlat(entryFlat), .msgReady(msgReady), .msgValid(msgValid),
    .msgVector(msgVector), .msgDelMode(msgDelMode), .msgDest(msgDest),
    .msgPhys(msgPhys), .msgLevel(msgLevel), .rirrSet(rirrSet), .rirrClr(rirrClr),
    .cmdErr(cmdErr), .underflowErr(underflowErr)
  );

  // reference model state
  int mCnt[NP];
  bit mPend[NP];
  bit mCmdErr, mUnder;
  bit expGrant;
  int expSel;
  logic [NP-1:0] expClr;
  int nChecks = 0;
  int nFail = 0;
  string curReq = "R2";

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [NP-1:0] expSet;
    bit expValid = 0;
    expSel = 0;
    for (int p = 0; p < NP; p++)
      if (mPend[p] && !tMask[p] && !expValid) begin expValid = 1; expSel = p; end
    expGrant = expValid && msgReady;
    chk(curReq, "msgValid", 64'(msgValid), 64'(expValid));
    if (expValid) begin
      chk("R6", "msgVector", 64'(msgVector), 64'(tVec[expSel]));
      chk("R6", "msgDelMode", 64'(msgDelMode), 64'(tDelm[expSel]));
      chk("R6", "msgDest", 64'(msgDest), 64'(tDest[expSel]));
      chk("R6", "msgPhys", 64'(msgPhys), 64'(!tDm[expSel]));
      chk("R6", "msgLevel", 64'(msgLevel), 64'(tLevel[expSel]));
    end
    expSet = '0;
    if (expGrant && tLevel[expSel]) expSet[expSel] = 1'b1;
    chk("R7", "rirrSet", 64'(rirrSet), 64'(expSet));
    expClr = '0;
    for (int p = 0; p < NP; p++)
      if (eoiValid && tRirr[p] && tVec[p] == eoiVector) expClr[p] = 1'b1;
    chk("R8", "rirrClr", 64'(rirrClr), 64'(expClr));
    chk("R4", "cmdErr", 64'(cmdErr), 64'(mCmdErr));
    chk("R3", "underflowErr", 64'(underflowErr), 64'(mUnder));
  endtask

  task automatic update();
    bit setB[NP];
    for (int p = 0; p < NP; p++) begin
      setB[p] = 0;
      if (expClr[p] && mCnt[p] > 0) setB[p] = 1;
      if (chkValid && int'(chkPin) == p && !tRirr[p] && mCnt[p] > 0) setB[p] = 1;
    end
    mCmdErr = cmdValid && (int'(cmdPin) >= NP);
    mUnder = 0;
    if (cmdValid && int'(cmdPin) < NP && cmdOp != 2'd3) begin
      int pn = int'(cmdPin);
      int old = mCnt[pn];
      int up = (old < MAXC) ? old + 1 : old;
      if (cmdOp != 2'd1 && old == 0) setB[pn] = 1;
      if (cmdOp == 2'd0)      mCnt[pn] = up;
      else if (cmdOp == 2'd1) mCnt[pn] = (old > MINC) ? old - 1 : old;
      else                    mCnt[pn] = up - 1;
      mUnder = mCnt[pn] < 0;
    end
    if (expGrant) mPend[expSel] = 0;
    for (int p = 0; p < NP; p++) if (expClr[p]) tRirr[p] = 1'b0;
    if (expGrant && tLevel[expSel]) tRirr[expSel] = 1'b1;
    for (int p = 0; p < NP; p++) mPend[p] = (mPend[p] || setB[p]) && !tMask[p];
  endtask

  task automatic tick();
    #1; compare();
    @(posedge clk); #1; update();
    @(negedge clk);
  endtask

  task automatic idleN(input int n);
    repeat (n) tick();
  endtask

  task automatic doCmd(input int pin, input logic [1:0] op);
    cmdValid = 1'b1; cmdPin = 6'(pin); cmdOp = op;
    tick();
    cmdValid = 1'b0;
  endtask

  task automatic doEoi(input logic [7:0] v);
    eoiValid = 1'b1; eoiVector = v;
    tick();
    eoiValid = 1'b0;
  endtask

  task automatic doChk(input int pin);
    chkValid = 1'b1; chkPin = 5'(pin);
    tick();
    chkValid = 1'b0;
  endtask

  bit finished = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      tVec[p] = 8'(8'h40 + p); tDelm[p] = 3'(p % 8); tDest[p] = 8'(p * 3);
      tDm[p] = p[0]; tLevel[p] = (p % 4 == 1); tMask[p] = (p == 7); tRirr[p] = 1'b0;
      mCnt[p] = 0; mPend[p] = 0;
    end
    tVec[9] = 8'h55; tVec[5] = 8'h55;
    mCmdErr = 0; mUnder = 0; expClr = '0; expGrant = 0; expSel = 0;
    rstN = 1'b0; cmdValid = 0; chkValid = 0; eoiValid = 0; msgReady = 1'b1;
    cmdOp = 0; cmdPin = 0; chkPin = 0; eoiVector = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "msgValid after reset", 64'(msgValid), 64'd0);
    chk("R1", "cmdErr after reset", 64'(cmdErr), 64'd0);
    chk("R1", "underflowErr after reset", 64'(underflowErr), 64'd0);
    chk("R1", "rirr strobes after reset", 64'({rirrSet, rirrClr}), 64'd0);
    @(negedge clk);

    // R2: shared line counting and the 0->1 edge
    curReq = "R2";
    doCmd(3, 2'd0); idleN(2);
    doCmd(3, 2'd0); idleN(2);
    doCmd(3, 2'd1); doCmd(3, 2'd1); idleN(2);
    curReq = "R3";
    doCmd(3, 2'd1); idleN(2);
    doCmd(3, 2'd0); idleN(2);
    doCmd(3, 2'd0); idleN(2);
    doCmd(3, 2'd1); idleN(1);
    curReq = "R2";
    doCmd(10, 2'd2); idleN(2);

    // R4: out-of-range pin
    curReq = "R4";
    doCmd(40, 2'd0); idleN(2);
    doCmd(32, 2'd2); idleN(2);

    // R5 and R9: masked pin, then unmask and check
    curReq = "R5";
    doCmd(7, 2'd0); idleN(2);
    doChk(7); idleN(1);
    curReq = "R9";
    tMask[7] = 1'b0; idleN(1);
    doChk(7); idleN(2);
    doCmd(7, 2'd1); idleN(1);

    // R10: stalled consumer then drain lowest first
    curReq = "R10";
    msgReady = 1'b0;
    doCmd(12, 2'd0); doCmd(2, 2'd0); doCmd(20, 2'd0); idleN(2);
    msgReady = 1'b1; idleN(5);
    doCmd(12, 2'd1); doCmd(2, 2'd1); doCmd(20, 2'd1);

    // R7 and R8: two level pins sharing a vector
    curReq = "R7";
    doCmd(5, 2'd0); doCmd(9, 2'd0); idleN(3);
    curReq = "R9";
    doChk(5); idleN(1);
    curReq = "R8";
    doEoi(8'h55); idleN(3);
    doCmd(9, 2'd1); idleN(1);
    doEoi(8'h55); idleN(3);
    doEoi(8'h12); idleN(2);
    doCmd(5, 2'd1); doEoi(8'h55); idleN(2);

    // R5: queued request dropped when pin is masked
    curReq = "R5";
    msgReady = 1'b0;
    doCmd(13, 2'd0); idleN(1);
    tMask[13] = 1'b1; idleN(2);
    tMask[13] = 1'b0; msgReady = 1'b1; idleN(3);
    doCmd(13, 2'd1);

    // R12: reserved code leaves the count at zero
    curReq = "R12";
    doCmd(14, 2'd3); idleN(2);
    doCmd(14, 2'd0); idleN(2);
    doCmd(14, 2'd1); idleN(1);

    // R11: saturation at both ends
    curReq = "R11";
    for (int k = 0; k < 130; k++) doCmd(30, 2'd0);
    for (int k = 0; k < MAXC; k++) doCmd(30, 2'd1);
    idleN(1);
    doCmd(30, 2'd0); idleN(2);
    for (int k = 0; k < 130; k++) doCmd(31, 2'd1);
    for (int k = 0; k < MAXC; k++) doCmd(31, 2'd0);
    doCmd(31, 2'd0); idleN(1);
    doCmd(31, 2'd0); idleN(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule